// File: doc/BRIEF.md
# Pattern-Stretched Fractional Clock Divider

This block derives a slower clock from one of two reference clock enables. Each output period lasts an integer number of source cycles, and some periods last one source cycle longer. A 16-bit stretch pattern chooses which periods are longer. The highest set bit of the pattern fixes the length of the repeating cycle, that bit's position plus one. Each set bit stretches exactly one period of that cycle. The average division ratio is therefore the integer divisor plus the count of set bits divided by the cycle length. For example, a pattern of 0x0110 adds 2/9, and a pattern of 0xFEEE adds 13/16.

The block runs on one fabric clock. The two references arrive as clock-enable strobes, and a select bit picks one of them. One cycle of the fabric clock in which the selected strobe is high counts as one source cycle. The output clock is registered and is high for the first half of each period, rounded down. A tick marks the final source cycle of each period. While the enable is low, the output and the tick stay low and the pattern walk is rewound. The next enabled period then starts a fresh pattern cycle.

Top module: `frac_clk_div`

## Requirements
- R1: A fabric clock cycle in which the selected strobe (`src_sel_i`=1 picks `ref_div1_ce_i`, 0 picks `ref_divn_ce_i`) is low changes neither output; the unselected strobe has no effect.
- R2: Each output period lasts E + b source cycles. E is the effective divisor and b is the pattern bit at the current index.
- R3: An integer divisor of 0 or 1 is treated as 2.
- R4: The pattern index starts at the highest set bit and steps down by one each period. After bit 0 it wraps back to the highest set bit, so 0x0110 gives stretch bits 1,0,0,0,1,0,0,0,0 and 0xFEEE gives 1111 1110 1110 1110.
- R5: A pattern of zero stretches no period, so every period equals E.
- R6: `clk_o` is high for the first floor(L/2) source cycles of a period of length L and low for the remaining cycles.
- R7: `tick_o` is high during the last source cycle of every period and low at all other times.
- R8: One source cycle with `en_i` low drives both outputs low. The next enable restarts the pattern at the highest set bit.
- R9: The divisor is sampled when a period begins. A divisor presented together with the rising enable governs the first period, and a change made inside a period takes effect at the next period.
- R10: During and right after reset, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_div1_ce_i | input | 1 | Strobe of the undivided reference |
| ref_divn_ce_i | input | 1 | Strobe of the pre-divided reference |
| src_sel_i | input | 1 | 1 picks ref_div1_ce_i, 0 picks ref_divn_ce_i |
| en_i | input | 1 | Run enable |
| int_div_i | input | 12 | Integer divisor, clamped to at least 2 |
| frac_pat_i | input | 16 | Stretch pattern |
| clk_o | output | 1 | Divided clock |
| tick_o | output | 1 | Marks the last source cycle of each period |

## Verification
If the position counter is wrong, the duty split or the tick moves inside the same period, so the error shows within one period. If the pattern index is wrong, a stretched period appears at the wrong place in the sequence, and a fault of this kind can take up to a full pattern cycle of 16 periods to show. For this reason the bench runs every pattern for at least one full wrap. Disable and re-enable sequences show a missed index rewind on the first period after the restart.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int unsigned DEF_INT_W  = 12;
    localparam int unsigned DEF_FRAC_W = 16;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/fcd_src_select.sv
module fcd_src_select (
    input  logic sel_i,
    input  logic ce_a_i,
    input  logic ce_b_i,
    output logic ce_o
);

    // sel_i high takes the undivided reference strobe
    always_comb begin
        ce_o = sel_i ? ce_a_i : ce_b_i;
    end

endmodule

// File: rtl/fcd_pattern_walker.sv
module fcd_pattern_walker #(
    parameter int unsigned FRAC_W = fcd_pkg::DEF_FRAC_W,
    localparam int unsigned IDX_W = (FRAC_W > 1) ? $clog2(FRAC_W) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce_i,
    input  logic              en_i,
    input  logic [FRAC_W-1:0] pat_i,
    input  logic              load_i,
    input  logic              first_i,
    output logic              bit_o
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } walk_t;

    walk_t            walk_d, walk_q;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] sel_idx;

    // Position of the highest set bit. A zero pattern gives index 0 with a
    // zero bit, so no period is stretched.
    always_comb begin
        top_idx = '0;
        for (int i = 0; i < int'(FRAC_W); i++) begin
            if (pat_i[i]) begin
                top_idx = IDX_W'(i);
            end
        end
    end

    // Index that the period starting now uses
    always_comb begin
        if (first_i || (walk_q.idx == '0)) begin
            sel_idx = top_idx;
        end else begin
            sel_idx = walk_q.idx - IDX_W'(1);
        end
        bit_o = pat_i[sel_idx];
    end

    always_comb begin
        walk_d = walk_q;
        if (ce_i && !en_i) begin
            walk_d.idx = top_idx;
        end else if (load_i) begin
            walk_d.idx = sel_idx;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    // R4: a continuing period steps the index down by one
    assert_index_steps_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !first_i && (walk_q.idx != '0)) |=> (walk_q.idx == $past(walk_q.idx) - IDX_W'(1)));

    // R8: a fresh start always begins at the highest set bit
    assert_restart_at_top_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && first_i) |=> (walk_q.idx == $past(top_idx)));

endmodule

// File: rtl/fcd_period_gen.sv
module fcd_period_gen #(
    parameter int unsigned INT_W = fcd_pkg::DEF_INT_W,
    localparam int unsigned LEN_W = INT_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ce_i,
    input  logic             en_i,
    input  logic [INT_W-1:0] div_i,
    input  logic             bit_i,
    output logic             load_o,
    output logic             first_o,
    output logic             clk_o,
    output logic             tick_o
);

    import fcd_pkg::*;

    typedef struct packed {
        phase_e           ph;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic             clk;
        logic             tick;
    } per_t;

    per_t             per_d, per_q;
    logic [LEN_W-1:0] div_eff;
    logic             at_last;

    always_comb begin
        if (div_i < INT_W'(2)) begin
            div_eff = LEN_W'(2);
        end else begin
            div_eff = {1'b0, div_i};
        end
    end

    always_comb begin
        at_last = (per_q.ph == PH_RUN) && (per_q.cnt == per_q.len - LEN_W'(1));
    end

    always_comb begin
        per_d   = per_q;
        load_o  = 1'b0;
        first_o = 1'b0;
        if (ce_i) begin
            if (!en_i) begin
                per_d.ph  = PH_IDLE;
                per_d.cnt = '0;
                per_d.len = '0;
            end else if ((per_q.ph == PH_IDLE) || at_last) begin
                load_o    = 1'b1;
                first_o   = (per_q.ph == PH_IDLE);
                per_d.ph  = PH_RUN;
                per_d.cnt = '0;
                per_d.len = div_eff + LEN_W'(bit_i);
            end else begin
                per_d.cnt = per_q.cnt + LEN_W'(1);
            end
            per_d.clk  = (per_d.ph == PH_RUN) && (per_d.cnt < (per_d.len >> 1));
            per_d.tick = (per_d.ph == PH_RUN) && (per_d.cnt == per_d.len - LEN_W'(1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            per_q <= '0;
        end else begin
            per_q <= per_d;
        end
    end

    always_comb begin
        clk_o  = per_q.clk;
        tick_o = per_q.tick;
    end

    // R1: without a source cycle nothing moves
    assert_hold_without_source_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ce_i |=> $stable(per_q));

    // R8: a disabled source cycle silences both outputs
    assert_disable_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_i && !en_i) |=> (!clk_o && !tick_o));

    // R3: a running period is never shorter than two cycles
    assert_min_length_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (per_q.ph == PH_RUN) |-> (per_q.len >= LEN_W'(2)));

    // R7: the tick falls in the low phase of the output
    assert_tick_in_low_phase_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> !clk_o);

    // R2: the position stays inside the period
    assert_count_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (per_q.ph == PH_RUN) |-> (per_q.cnt < per_q.len));

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
    parameter int unsigned INT_W  = fcd_pkg::DEF_INT_W,
    parameter int unsigned FRAC_W = fcd_pkg::DEF_FRAC_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ref_div1_ce_i,
    input  logic              ref_divn_ce_i,
    input  logic              src_sel_i,
    input  logic              en_i,
    input  logic [INT_W-1:0]  int_div_i,
    input  logic [FRAC_W-1:0] frac_pat_i,
    output logic              clk_o,
    output logic              tick_o
);

    logic src_ce;
    logic load;
    logic first;
    logic stretch;

    fcd_src_select u_src_select (
        .sel_i  (src_sel_i),
        .ce_a_i (ref_div1_ce_i),
        .ce_b_i (ref_divn_ce_i),
        .ce_o   (src_ce)
    );

    fcd_pattern_walker #(
        .FRAC_W (FRAC_W)
    ) u_walker (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ce_i    (src_ce),
        .en_i    (en_i),
        .pat_i   (frac_pat_i),
        .load_i  (load),
        .first_i (first),
        .bit_o   (stretch)
    );

    fcd_period_gen #(
        .INT_W (INT_W)
    ) u_period (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ce_i    (src_ce),
        .en_i    (en_i),
        .div_i   (int_div_i),
        .bit_i   (stretch),
        .load_o  (load),
        .first_o (first),
        .clk_o   (clk_o),
        .tick_o  (tick_o)
    );

endmodule

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce1 = 1'b0;
    logic        cen = 1'b0;
    logic        sel = 1'b1;
    logic        en = 1'b0;
    logic [11:0] int_div = '0;
    logic [15:0] frac = '0;
    logic        clk_o;
    logic        tick_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int hold_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_clk_div u_frac_clk_div (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .ref_div1_ce_i (ce1),
        .ref_divn_ce_i (cen),
        .src_sel_i     (sel),
        .en_i          (en),
        .int_div_i     (int_div),
        .frac_pat_i    (frac),
        .clk_o         (clk_o),
        .tick_o        (tick_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int top_of(input int pat);
        int t = 0;
        for (int i = 0; i < 16; i++) if ((pat >> i) & 1) t = i;
        return t;
    endfunction

    function automatic int eff_div(input int d);
        return (d < 2) ? 2 : d;
    endfunction

    // One source cycle of the selected reference; the unselected strobe is random
    task automatic step_src();
        logic c0, t0;
        if (sel) begin
            ce1 = 1'b1;
            cen = 1'($urandom % 2);
            @(posedge clk); @(negedge clk);
        end else begin
            cen = 1'b0;
            ce1 = 1'($urandom % 2);
            c0 = clk_o; t0 = tick_o;
            @(posedge clk); @(negedge clk);
            if (clk_o !== c0 || tick_o !== t0) hold_bad++;  // R1 idle cycle
            cen = 1'b1;
            ce1 = 1'($urandom % 2);
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic run_case(input string tag, input bit s, input int div, input int pat,
                            input int periods, input int new_div);
        int top, idx, len, d, act_c, act_t, exp_c, exp_t;
        bit bad;
        @(negedge clk);
        sel = s; int_div = 12'(div); frac = 16'(pat); en = 1'b1;
        step_src();
        top = top_of(pat); idx = top; d = div;
        for (int p = 0; p < periods; p++) begin
            len = eff_div(d) + ((pat >> idx) & 1);
            bad = 0; act_c = 0; act_t = 0; exp_c = 0; exp_t = 0;
            for (int c = 0; c < len; c++) begin
                if (clk_o !== (c < len / 2) || tick_o !== (c == len - 1)) begin
                    if (!bad) begin
                        act_c = clk_o; act_t = tick_o;
                        exp_c = (c < len / 2); exp_t = (c == len - 1);
                    end
                    bad = 1;
                end
                if (p == 0 && c == 0 && new_div >= 0) begin
                    int_div = 12'(new_div);
                    d = new_div;
                end
                step_src();
            end
            check(!bad, tag, $sformatf("period %0d len %0d clk", p, len), act_c, exp_c);
            if (bad) check(act_t == exp_t, tag, "tick", act_t, exp_t);
            idx = (idx == 0) ? top : idx - 1;
        end
        en = 1'b0;
        step_src();
        check(clk_o === 1'b0 && tick_o === 1'b0, "R8", "outputs after disable",
              int'(clk_o) + 2 * int'(tick_o), 0);
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        ce1 = 1'b1;
        @(negedge clk);
        check(clk_o === 1'b0 && tick_o === 1'b0, "R10", "outputs in reset",
              int'(clk_o) + 2 * int'(tick_o), 0);
        rst_n = 1'b1;
        ce1 = 1'b0;
        @(negedge clk);
        check(clk_o === 1'b0 && tick_o === 1'b0, "R10", "outputs after reset",
              int'(clk_o) + 2 * int'(tick_o), 0);

        run_case("R5", 1'b1, 5, 16'h0000, 4, -1);
        run_case("R4", 1'b1, 4, 16'h0110, 18, -1);
        run_case("R4", 1'b0, 3, 16'hFEEE, 17, -1);
        run_case("R3", 1'b1, 0, 16'h0000, 3, -1);
        run_case("R3", 1'b0, 1, 16'h0005, 4, -1);
        run_case("R6", 1'b1, 2, 16'h0002, 4, -1);
        run_case("R9", 1'b1, 4, 16'h0000, 3, 7);
        run_case("R9", 1'b0, 9, 16'h0003, 3, 2);
        // R8 restart: stop mid-pattern then check the walk begins again at the top
        run_case("R8", 1'b1, 4, 16'h0110, 3, -1);
        run_case("R8", 1'b1, 4, 16'h0110, 2, -1);

        for (int k = 0; k < 24; k++) begin
            int pat, w, div, per;
            w   = $urandom % 17;
            pat = (w == 0) ? 0 : int'($urandom & ((32'd1 << w) - 1));
            div = $urandom % 14;
            per = top_of(pat) + 4;
            run_case("R2", 1'($urandom % 2), div, pat, per, ($urandom % 4 == 0) ? int'($urandom % 10) : -1);
        end

        check(hold_bad == 0, "R1", "output changes without selected strobe", hold_bad, 0);
        check(checks > 12, "R7", "check count", checks, 13);

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule